// File: doc/BRIEF.md
# Table-Driven Parallel Prefix Evaluator

This block runs a finite state machine over a wide stream of symbols, several symbols per clock. The machine is given in its semigroup form. A small table turns each symbol into an element. A programmable square table then combines two elements into one. Because that combination is associative, the elements of one input word can be folded together by a pipelined prefix network instead of one symbol at a time.

Each lane of the output reports whether the product of all elements from the start of the stream up to and including that lane's symbol is numerically greater than a programmable threshold element. The last product of every word is kept as a carry and placed on the left of the next word, so words can arrive on every cycle with no gaps.

The operation table, the symbol map and the threshold are written through one configuration port. Software must load them before the stream starts. Writes are honoured only while the block reports that it is idle.

Top module: `sg_prefix_eval`

## Requirements
- R1: For lane i of a word, `out_accept[i]` is 1 exactly when the left-to-right product of every mapped symbol since reset, up to and including lane i, is numerically greater than the threshold. Lane 0 is the earliest symbol of the word.
- R2: `out_valid` is high on the 2·log2(LANES)+1-th rising edge, counting the edge that samples `in_valid`. This is 7 edges for 8 lanes. `out_valid` is high at no other time.
- R3: Words presented on consecutive cycles give outputs on consecutive cycles. The product carries from each word into the next.
- R4: Idle cycles between words leave the carried product unchanged.
- R5: The operation table entry at address left·2^EW + right (EW = ceil(log2 ELEMS)) holds left⊕right, and the earlier operand is always the left one. `cfg_sel` picks the target: 0 is the operation table, 1 is the symbol map (addressed by the symbol value), and 2 is the threshold.
- R6: A configuration write made while `busy` is 1 changes none of the tables and not the threshold.
- R7: `busy` is 1 while a word is being presented or is in flight. It is 0 on the cycle after the last output has left.
- R8: Reset clears `out_valid` and `busy` and drops the carried product, so the next word starts a fresh fold. Table and threshold contents survive reset.
- R9: A product equal to the threshold does not accept. A product one above it does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 operation table, 1 symbol map, 2 threshold |
| cfg_addr | input | 2·EW | Table address (left·2^EW+right, or symbol value) |
| cfg_data | input | EW | Element value to write |
| busy | output | 1 | Stream activity; configuration writes are ignored while high |
| in_valid | input | 1 | Word of symbols present |
| in_sym | input | LANES×SYM_W | Symbols, lane 0 earliest |
| out_valid | output | 1 | Accept flags present |
| out_accept | output | LANES | Per-lane accept flags |

## Verification
Assertions check on every cycle that each pipeline stage's valid bit follows the one before it, and that the output stage fires only one cycle after its input. They also check that the carried product holds through idle cycles, that a table write lands at its address, and that a locked threshold write leaves the threshold stable. Only the bench's scenarios can show that the prefix network produces correct products. It compares them against a sequential fold over a non-commutative table, across streaming, gapped, reset and locked-write runs, and at the exact threshold boundary.

// File: rtl/sg_pkg.sv
package sg_pkg;

    typedef enum logic [1:0] {
        CFG_OPTAB  = 2'd0,
        CFG_SYMMAP = 2'd1,
        CFG_THRESH = 2'd2
    } cfg_tgt_e;

    // Operand distance for a node of the pipelined prefix network.
    // Levels 1..lg reduce upward, levels lg+1..2lg-1 spread back down.
    // Zero means the lane passes its value through unchanged.
    function automatic int bk_stride(input int lvl, input int lane, input int lg);
        int l;
        int s;
        if (lvl <= lg) begin
            l = lvl - 1;
            s = 1 << l;
            if (((lane + 1) % (2 * s)) == 0) return s;
            return 0;
        end
        l = 2 * lg - 1 - lvl;
        s = 1 << l;
        if ((((lane + 1) % (2 * s)) == s) && ((lane + 1) > s)) return s;
        return 0;
    endfunction

endpackage

// File: rtl/sg_cfg_ram.sv
module sg_cfg_ram #(
    parameter int ENTRIES = 16,
    parameter int AW      = 4,
    parameter int W       = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we_i,
    input  logic [AW-1:0]               addr_i,
    input  logic [W-1:0]                data_i,
    output logic [ENTRIES-1:0][W-1:0]   mem_o
);

    logic [ENTRIES-1:0][W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we_i) mem_d[addr_i] = data_i;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign mem_o = mem_q;

    assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we_i) |-> (mem_q[$past(addr_i)] == $past(data_i)));

endmodule

// File: rtl/sg_prefix_pipe.sv
module sg_prefix_pipe #(
    parameter int LANES = 8,
    parameter int EW    = 5
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [(1<<(2*EW))-1:0][EW-1:0]     tbl_i,
    input  logic                               vld_i,
    input  logic [LANES-1:0][EW-1:0]           elem_i,
    output logic                               vld_o,
    output logic [LANES-1:0][EW-1:0]           pfx_o,
    output logic                               busy_o
);

    localparam int LG   = $clog2(LANES);
    localparam int NLVL = 2 * LG - 1;

    typedef struct packed {
        logic [NLVL:0]                        vld;
        logic [NLVL:0][LANES-1:0][EW-1:0]     v;
    } pipe_t;

    pipe_t st_d, st_q;
    logic [NLVL:1][LANES-1:0][EW-1:0] node_res;

    for (genvar j = 1; j <= NLVL; j++) begin : g_lvl
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            localparam int STR = sg_pkg::bk_stride(j, i, LG);
            if (STR > 0) begin : g_op
                assign node_res[j][i] = tbl_i[{st_q.v[j-1][i-STR], st_q.v[j-1][i]}];
            end else begin : g_pass
                assign node_res[j][i] = st_q.v[j-1][i];
            end
        end

        assert_stage_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.vld[j] == $past(st_q.vld[j-1]));
    end

    always_comb begin
        st_d        = st_q;
        st_d.vld[0] = vld_i;
        st_d.v[0]   = elem_i;
        for (int j = 1; j <= NLVL; j++) begin
            st_d.vld[j] = st_q.vld[j-1];
            st_d.v[j]   = node_res[j];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o  = st_q.vld[NLVL];
    assign pfx_o  = st_q.v[NLVL];
    assign busy_o = |st_q.vld;

endmodule

// File: rtl/sg_carry_join.sv
module sg_carry_join #(
    parameter int LANES = 8,
    parameter int EW    = 5
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [(1<<(2*EW))-1:0][EW-1:0]     tbl_i,
    input  logic [EW-1:0]                      thr_i,
    input  logic                               vld_i,
    input  logic [LANES-1:0][EW-1:0]           pfx_i,
    output logic                               vld_o,
    output logic [LANES-1:0]                   acc_o
);

    typedef struct packed {
        logic               vld;
        logic               have;
        logic [EW-1:0]      carry;
        logic [LANES-1:0]   acc;
    } join_t;

    join_t st_d, st_q;
    logic [LANES-1:0][EW-1:0] joined;
    logic [LANES-1:0][EW-1:0] full;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign joined[i] = tbl_i[{st_q.carry, pfx_i[i]}];
        assign full[i]   = st_q.have ? joined[i] : pfx_i[i];
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        for (int i = 0; i < LANES; i++) begin
            st_d.acc[i] = full[i] > thr_i;
        end
        if (vld_i) begin
            st_d.carry = full[LANES-1];
            st_d.have  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign acc_o = st_q.acc;

    assert_out_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld == $past(vld_i));

    assert_idle_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> ($stable(st_q.carry) && $stable(st_q.have)));

endmodule

// File: rtl/sg_prefix_eval.sv
module sg_prefix_eval #(
    parameter int LANES = 8,
    parameter int ELEMS = 25,
    parameter int SYM_W = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cfg_we,
    input  logic [1:0]                             cfg_sel,
    input  logic [2*$clog2(ELEMS)-1:0]             cfg_addr,
    input  logic [$clog2(ELEMS)-1:0]               cfg_data,
    output logic                                   busy,
    input  logic                                   in_valid,
    input  logic [LANES-1:0][SYM_W-1:0]            in_sym,
    output logic                                   out_valid,
    output logic [LANES-1:0]                       out_accept
);

    import sg_pkg::*;

    localparam int EW    = $clog2(ELEMS);
    localparam int AW    = 2 * EW;
    localparam int DEPTH = 1 << AW;
    localparam int NSYM  = 1 << SYM_W;

    typedef struct packed {
        logic [EW-1:0] thr;
    } top_t;

    top_t st_d, st_q;

    cfg_tgt_e                  tgt;
    logic                      wr_ok;
    logic                      tree_busy;
    logic [DEPTH-1:0][EW-1:0]  op_tbl;
    logic [NSYM-1:0][EW-1:0]   map_tbl;
    logic [LANES-1:0][EW-1:0]  elem;
    logic                      tree_vld;
    logic [LANES-1:0][EW-1:0]  tree_pfx;

    assign tgt   = cfg_tgt_e'(cfg_sel);
    assign busy  = in_valid | tree_busy | out_valid;
    assign wr_ok = cfg_we & ~busy;

    sg_cfg_ram #(.ENTRIES(DEPTH), .AW(AW), .W(EW)) u_optab (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (wr_ok && (tgt == CFG_OPTAB)),
        .addr_i (cfg_addr),
        .data_i (cfg_data),
        .mem_o  (op_tbl)
    );

    sg_cfg_ram #(.ENTRIES(NSYM), .AW(SYM_W), .W(EW)) u_symmap (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (wr_ok && (tgt == CFG_SYMMAP)),
        .addr_i (cfg_addr[SYM_W-1:0]),
        .data_i (cfg_data),
        .mem_o  (map_tbl)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_map
        assign elem[i] = map_tbl[in_sym[i]];
    end

    always_comb begin
        st_d = st_q;
        if (wr_ok && (tgt == CFG_THRESH)) st_d.thr = cfg_data;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    sg_prefix_pipe #(.LANES(LANES), .EW(EW)) u_tree (
        .clk    (clk),
        .rst_n  (rst_n),
        .tbl_i  (op_tbl),
        .vld_i  (in_valid),
        .elem_i (elem),
        .vld_o  (tree_vld),
        .pfx_o  (tree_pfx),
        .busy_o (tree_busy)
    );

    sg_carry_join #(.LANES(LANES), .EW(EW)) u_join (
        .clk    (clk),
        .rst_n  (rst_n),
        .tbl_i  (op_tbl),
        .thr_i  (st_q.thr),
        .vld_i  (tree_vld),
        .pfx_i  (tree_pfx),
        .vld_o  (out_valid),
        .acc_o  (out_accept)
    );

    assert_locked_thresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_we && (cfg_sel == 2'd2)) |=> $stable(st_q.thr));

    assert_reset_quiet_R8: assert property (@(posedge clk)
        $past(!rst_n) |-> !out_valid);

endmodule

// File: tb/sg_prefix_eval_test.sv
module sg_prefix_eval_test;

    localparam int LANES = 8;
    localparam int LG    = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_sel = 2'd0;
    logic [9:0]       cfg_addr = '0;
    logic [4:0]       cfg_data = '0;
    logic             busy;
    logic             in_valid = 1'b0;
    logic [7:0][1:0]  in_sym = '0;
    logic             out_valid;
    logic [7:0]       out_accept;

    sg_prefix_eval #(.LANES(8), .ELEMS(25), .SYM_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .busy(busy),
        .in_valid(in_valid), .in_sym(in_sym),
        .out_valid(out_valid), .out_accept(out_accept)
    );

    always #10 clk = ~clk;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    int m_acc = 0;
    bit m_have = 0;
    int thr_m = 0;
    int map_m [4] = '{11, 8, 15, 4};
    logic [7:0] exp_q [$];
    int in_cyc_q [$];
    logic [7:0] last_acc = '0;
    string cur_req = "R1";
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // affine maps x -> m*x+c mod 5, element = m*5+c, left applied first
    function automatic int opm(input int a, input int b);
        int ma = a / 5, ca = a % 5, mb = b / 5, cb = b % 5;
        return ((mb * ma) % 5) * 5 + ((mb * ca + cb) % 5);
    endfunction

    // output monitor: compares each word against the sequential fold
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            last_acc = out_accept;
            if (exp_q.size() == 0) begin
                check(0, "R2", "unexpected out_valid", 1, 0);
            end else begin
                logic [7:0] e;
                int ic;
                e  = exp_q.pop_front();
                ic = in_cyc_q.pop_front();
                check(out_accept == e, cur_req, "accept vector", out_accept, e);
                check((cyc - ic) == 2 * LG, "R2", "latency edges after capture", cyc - ic, 2 * LG);
            end
        end
    end

    task automatic cfg_write(input int sel, input int addr, input int data);
        cfg_we = 1'b1; cfg_sel = sel[1:0]; cfg_addr = addr[9:0]; cfg_data = data[4:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send_word(input logic [7:0][1:0] s);
        logic [7:0] e;
        in_valid = 1'b1;
        in_sym   = s;
        for (int i = 0; i < LANES; i++) begin
            int x = map_m[s[i]];
            m_acc  = m_have ? opm(m_acc, x) : x;
            m_have = 1;
            e[i]   = (m_acc > thr_m);
        end
        exp_q.push_back(e);
        in_cyc_q.push_back(cyc + 1);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [7:0][1:0] rnd_word();
        logic [7:0][1:0] w;
        for (int i = 0; i < LANES; i++) w[i] = 2'($urandom_range(3, 0));
        return w;
    endfunction

    task automatic drain(input string req);
        int guard = 0;
        while ((exp_q.size() != 0) && (guard < 40)) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        check(busy == 1'b0, req, "busy after drain", busy, 0);
        check(exp_q.size() == 0, req, "words outstanding", exp_q.size(), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        m_have = 0;
        check(out_valid == 1'b0, "R8", "out_valid in reset", out_valid, 0);
        check(busy == 1'b0, "R8", "busy in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_load();
        for (int a = 0; a < 25; a++)
            for (int b = 0; b < 25; b++)
                cfg_write(0, a * 32 + b, opm(a, b));   // R5 address layout
        for (int s = 0; s < 4; s++) cfg_write(1, s, map_m[s]);
        thr_m = 17;
        cfg_write(2, 0, thr_m);
    endtask

    task automatic t_single();
        cur_req = "R1";
        send_word(rnd_word());
        for (int k = 0; k < 2 * LG - 1; k++) begin
            check(busy == 1'b1, "R7", "busy while in flight", busy, 1);
            check(out_valid == 1'b0, "R2", "early out_valid", out_valid, 0);
            @(negedge clk);
        end
        drain("R7");
    endtask

    task automatic t_stream();
        cur_req = "R3";
        for (int k = 0; k < 10; k++) send_word(rnd_word());
        drain("R3");
    endtask

    task automatic t_gaps();
        cur_req = "R4";
        for (int k = 0; k < 8; k++) begin
            send_word(rnd_word());
            repeat (k % 4) @(negedge clk);
        end
        drain("R4");
    endtask

    task automatic t_locked();
        cur_req = "R6";
        for (int k = 0; k < 4; k++) begin
            if (k == 1) begin cfg_we = 1'b1; cfg_sel = 2'd0; cfg_addr = 10'(11 * 32 + 11); cfg_data = 5'd0; end
            if (k == 2) begin cfg_we = 1'b1; cfg_sel = 2'd1; cfg_addr = 10'd0; cfg_data = 5'd3; end
            if (k == 3) begin cfg_we = 1'b1; cfg_sel = 2'd2; cfg_addr = 10'd0; cfg_data = 5'd31; end
            send_word(rnd_word());
            cfg_we = 1'b0;
        end
        drain("R6");
        send_word('{default: 2'd0});
        drain("R6");
    endtask

    task automatic t_reset_fresh();
        cur_req = "R8";
        send_word(rnd_word());
        drain("R8");
        do_reset();
        send_word('{2'd3, 2'd1, 2'd2, 2'd0, 2'd0, 2'd2, 2'd1, 2'd3});
        drain("R8");
    endtask

    task automatic t_order();
        cur_req = "R5";
        do_reset();
        thr_m = 7;
        cfg_write(2, 0, thr_m);
        // lane0 element 11, lane1 element 15: 11 then 15 gives 8, reversed gives 6
        send_word('{2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd2, 2'd0});
        drain("R5");
        check(last_acc[1] == 1'b1, "R5", "left operand is earlier lane", last_acc[1], 1);
    endtask

    task automatic t_thresh_edge();
        cur_req = "R9";
        do_reset();
        thr_m = 11;
        cfg_write(2, 0, thr_m);
        send_word('{default: 2'd0});
        drain("R9");
        check(last_acc[0] == 1'b0, "R9", "product equal to threshold", last_acc[0], 0);
        do_reset();
        thr_m = 10;
        cfg_write(2, 0, thr_m);
        send_word('{default: 2'd0});
        drain("R9");
        check(last_acc[0] == 1'b1, "R9", "product one above threshold", last_acc[0], 1);
        thr_m = 17;
        cfg_write(2, 0, thr_m);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R8", "reset out_valid", out_valid, 0);
        check(busy == 1'b0, "R8", "reset busy", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        t_load();
        t_single();
        t_stream();
        t_gaps();
        t_locked();
        t_reset_fresh();
        t_order();
        t_thresh_edge();
        cur_req = "R1";
        for (int k = 0; k < 6; k++) send_word(rnd_word());
        drain("R1");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule